// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers up to 32 interrupt sources into one bank of memory-mapped registers and gives a host per-bit control over them. A one-cycle pulse on a source input latches into a cause register. Software can also raise a cause directly through a write-only alias. A mask register hides causes from the interrupt line. The mask is written whole, or bit by bit through a set-only alias and a clear-only alias. The single interrupt output is high whenever any unmasked cause is held.

Each cause bit is configured on its own through a control register. It either clears when software writes a one to it, or clears when software reads it. A masked view of the cause register shows only the unmasked causes and obeys the same per-bit clearing rule. The host reaches the bank over a simple register bus with a word address, write strobe, write data, read strobe and registered read data.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the cause register is all zeros, the mask is all ones, the control register is all zeros and `irq_out` is low.
- R2: Word addresses are 0 control, 1 cause, 2 masked cause, 3 cause-set, 4 mask value, 5 mask-set, 6 mask-clear. Read data appears on `bus_rdata` on the clock edge that samples `bus_rd`. Address 7 reads as zero and writes to it change nothing.
- R3: A source input held high at a clock edge sets the cause bit at the same position.
- R4: Writing to the cause-set word sets every cause bit whose write-data bit is 1. Zero bits leave the cause unchanged.
- R5: For a bit whose control bit is 0, writing a 1 to the cause word clears that cause bit. Writing a 0 has no effect.
- R6: For a bit whose control bit is 1, a read of the cause word returns the bit and then clears it. Writes to the cause word have no effect on that bit.
- R7: The masked-cause word reads as cause AND NOT mask. Clearing through it, by write-one or by read according to the control bit, clears only bits visible in that view.
- R8: The mask value word is read/write. A 1 in the mask-set word sets the mask bit, a 1 in the mask-clear word clears it, and 0 bits in either alias leave the mask unchanged.
- R9: Reads of the cause-set, mask-set and mask-clear words return zero. When `MASK_ALIAS_READ` is 1, the mask-set and mask-clear words instead return the mask value.
- R10: When a source asserts in the same cycle that its cause bit is being cleared by write or by read, the bit stays set.
- R11: `irq_out` is a register. After every clock edge it equals the OR of the cause bits that are not masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | N | Interrupt source events, one bit per source |
| bus_addr | input | 3 | Word address within the bank |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | N | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | N | Registered read data |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Causes are raised three ways: by source pulses, by the set alias, and by a source pulse that lands in the same cycle as a clear. Comparing the results tells the latch path apart from the software path and shows which one wins. The control register is then loaded with a mixed pattern, some bits clear-on-write and some clear-on-read. One write or read therefore shows both clearing rules side by side, through both the raw cause view and the masked view. A partial mask keeps a clear through the masked view from reaching hidden bits. The mask is driven through its value word and both aliases, and the interrupt line is sampled as causes come and go under full, partial and empty masks.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int N = 32,
  parameter bit MASK_ALIAS_READ = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_pulse,
  input  logic [2:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [N-1:0] bus_wdata,
  input  logic         bus_rd,
  output logic [N-1:0] bus_rdata,
  output logic         irq_out
);

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_CAUSE = 3'd1;
  localparam logic [2:0] A_VIEW  = 3'd2;
  localparam logic [2:0] A_CSET  = 3'd3;
  localparam logic [2:0] A_MVAL  = 3'd4;
  localparam logic [2:0] A_MSET  = 3'd5;
  localparam logic [2:0] A_MCLR  = 3'd6;
  localparam logic [N-1:0] ZERO  = '0;

  logic [N-1:0] cause_q, mask_q, ctrl_q;
  logic [N-1:0] cause_d, mask_d, view;
  logic [N-1:0] wr_clr, rd_clr, rd_mux;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_cause = bus_wr && bus_addr == A_CAUSE;
  wire wr_view  = bus_wr && bus_addr == A_VIEW;
  wire wr_cset  = bus_wr && bus_addr == A_CSET;
  wire wr_mval  = bus_wr && bus_addr == A_MVAL;
  wire wr_mset  = bus_wr && bus_addr == A_MSET;
  wire wr_mclr  = bus_wr && bus_addr == A_MCLR;
  wire rd_cause = bus_rd && bus_addr == A_CAUSE;
  wire rd_view  = bus_rd && bus_addr == A_VIEW;

  assign view   = cause_q & ~mask_q;
  assign wr_clr = ((wr_cause ? bus_wdata : ZERO) |
                   (wr_view ? (bus_wdata & ~mask_q) : ZERO)) & ~ctrl_q;
  assign rd_clr = ((rd_cause ? cause_q : ZERO) |
                   (rd_view ? view : ZERO)) & ctrl_q;
  assign cause_d = (cause_q & ~(wr_clr | rd_clr)) |
                   (wr_cset ? bus_wdata : ZERO) | src_pulse;
  assign mask_d  = wr_mval ? bus_wdata :
                   (mask_q | (wr_mset ? bus_wdata : ZERO)) &
                   ~(wr_mclr ? bus_wdata : ZERO);

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = ctrl_q;
      A_CAUSE: rd_mux = cause_q;
      A_VIEW:  rd_mux = view;
      A_MVAL:  rd_mux = mask_q;
      A_MSET,
      A_MCLR:  rd_mux = MASK_ALIAS_READ ? mask_q : ZERO;
      default: rd_mux = ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q   <= '0;
      mask_q    <= '1;
      ctrl_q    <= '0;
      irq_out   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      cause_q <= cause_d;
      mask_q  <= mask_d;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      irq_out <= |(cause_d & ~mask_d);
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/irq_cause_bank_chk.sv
module irq_cause_bank_chk #(
  parameter int N = 32,
  parameter bit MASK_ALIAS_READ = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] src_pulse,
  input logic [2:0]   bus_addr,
  input logic         bus_wr,
  input logic [N-1:0] bus_wdata,
  input logic         bus_rd,
  input logic [N-1:0] bus_rdata,
  input logic         irq_out,
  input logic [N-1:0] cause,
  input logic [N-1:0] mask
);

  p_irq_tracks_view_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_out == |(cause & ~mask));

  p_src_latches_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((cause & $past(src_pulse)) == $past(src_pulse)));

  p_cause_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3) |=> ((cause & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd5) |=> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  p_mask_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd6) |=> ((mask & $past(bus_wdata)) == '0));

  p_cset_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd3) |=> bus_rdata == '0);

  p_mask_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr) |=> $stable(mask));

endmodule

bind irq_cause_bank irq_cause_bank_chk #(.N(N), .MASK_ALIAS_READ(MASK_ALIAS_READ)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .cause(cause_q), .mask(mask_q)
);

// File: tb/irq_cause_bank_bench.sv
module irq_cause_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pulse = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_cause_bank u_irq_cause_bank (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk);
    src_pulse = s;
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq after reset", {31'd0, irq_out}, 32'd0);
    rd(3'd0, d); check("R1 ctrl reset", d, 32'd0);
    rd(3'd1, d); check("R1 cause reset", d, 32'd0);
    rd(3'd4, d); check("R1 mask reset", d, 32'hFFFF_FFFF);
    rd(3'd7, d); check("R2 addr7 reads zero", d, 32'd0);
    wr(3'd7, 32'h1234_5678);
    rd(3'd0, d); check("R2 addr7 write ignored ctrl", d, 32'd0);
    rd(3'd4, d); check("R2 addr7 write ignored mask", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_source();
    logic [31:0] d;
    pulse(32'h5);
    check("R11 masked source no irq", {31'd0, irq_out}, 32'd0);
    rd(3'd1, d); check("R3 source latched", d, 32'h5);
    wr(3'd6, 32'h1);
    check("R11 irq after unmask", {31'd0, irq_out}, 32'd1);
    rd(3'd2, d); check("R7 masked view", d, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(3'd1, 32'h4);
    rd(3'd1, d); check("R5 w1c clears bit2", d, 32'h1);
    wr(3'd1, 32'h0);
    rd(3'd1, d); check("R5 zero write no effect", d, 32'h1);
    wr(3'd1, 32'h1);
    rd(3'd1, d); check("R5 w1c clears bit0", d, 32'h0);
    check("R11 irq drops", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_cset();
    logic [31:0] d;
    wr(3'd3, 32'h8000_0000);
    rd(3'd1, d); check("R4 set alias", d, 32'h8000_0000);
    rd(3'd3, d); check("R9 cset reads zero", d, 32'h0);
    wr(3'd1, 32'h8000_0000);
  endtask

  task automatic t_cor();
    logic [31:0] d;
    wr(3'd0, 32'hF0);
    rd(3'd0, d); check("R2 ctrl readback", d, 32'hF0);
    wr(3'd3, 32'hF1);
    wr(3'd1, 32'hF1);
    rd(3'd1, d); check("R6 write ignored on cor bits", d, 32'hF0);
    rd(3'd1, d); check("R6 read cleared cor bits", d, 32'h0);
  endtask

  task automatic t_view();
    logic [31:0] d;
    wr(3'd6, 32'h30);
    rd(3'd4, d); check("R8 mask clear alias", d, 32'hFFFF_FFCE);
    wr(3'd3, 32'hF3);
    rd(3'd2, d); check("R7 view read", d, 32'h31);
    wr(3'd2, 32'h3);
    wr(3'd0, 32'h0);
    rd(3'd1, d); check("R7 view clears only visible", d, 32'hC2);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); check("R5 clear all", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(3'd4, 32'h0F0F_0F0F);
    rd(3'd4, d); check("R8 mask value", d, 32'h0F0F_0F0F);
    wr(3'd5, 32'hF000_0000);
    rd(3'd4, d); check("R8 mask set alias", d, 32'hFF0F_0F0F);
    wr(3'd6, 32'h0F00_0000);
    rd(3'd4, d); check("R8 mask clear alias", d, 32'hF00F_0F0F);
    rd(3'd5, d); check("R9 mset reads zero", d, 32'h0);
    rd(3'd6, d); check("R9 mclr reads zero", d, 32'h0);
    wr(3'd4, 32'h0);
    pulse(32'h0100_0000);
    check("R11 irq unmasked source", {31'd0, irq_out}, 32'd1);
    wr(3'd5, 32'h0100_0000);
    check("R11 irq masked again", {31'd0, irq_out}, 32'd0);
    wr(3'd4, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(3'd3, 32'h2);
    @(negedge clk);
    bus_addr = 3'd1; bus_wdata = 32'h2; bus_wr = 1'b1; src_pulse = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; src_pulse = '0;
    rd(3'd1, d); check("R10 source beats w1c", d, 32'h2);
    wr(3'd0, 32'h2);
    @(negedge clk);
    bus_addr = 3'd1; bus_rd = 1'b1; src_pulse = 32'h2;
    @(negedge clk);
    bus_rd = 1'b0; src_pulse = '0;
    check("R6 cor read data", bus_rdata, 32'h2);
    rd(3'd2, d); check("R10 source beats cor", d, 32'h2);
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h2);
    rd(3'd1, d); check("R5 final clear", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_source();
    t_w1c();
    t_cset();
    t_cor();
    t_view();
    t_mask();
    t_race();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule